// File: doc/BRIEF.md
# Serial receive start and bit-clock controller

This block is the control half of the receive side of a synchronous serial port. It works entirely in one system clock domain. Each candidate bit-clock source reaches it as a pair of single-cycle strobes, one for the rising edge and one for the falling edge. There are three candidates: a divided internal clock, the transmitter's clock and an external receive clock pin. The block picks one source. It can qualify that source by the level of the frame sync. It then turns the source into two enables: a data-sample enable and a frame-sync-output shift enable. Which edge drives which enable depends on a programmable inversion bit.

The block also decides when a receive word begins. The start condition is programmable and can be one of these:
- continuous back-to-back words;
- the transmitter's start event;
- a level, a falling edge, a rising edge or any transition of the synchronised frame sync;
- a compare-match flag.

A word counter keeps a busy flag high until the programmed number of bits has been sampled. A single-cycle start pulse tells the downstream shift register to begin. A clock output enable and a clock output level let the port drive its own receive clock pin, either all the time or only during a word.

Top module: `rx_start_clk_ctrl`

## Requirements
- R1: While reset is asserted, smp_en, fs_out_en, clk_out_en, clk_out_val, start_pulse and busy are all 0.
- R2: cfg_clk_src selects the bit-clock strobes: 0 = div_rise/div_fall, 1 = tx_rise/tx_fall, 2 = pin_rise/pin_fall, and 3 selects nothing, so no enable is ever produced.
- R3: With cfg_inv = 1, smp_en follows the selected rise strobe and fs_out_en follows the selected fall strobe in the same cycle. With cfg_inv = 0 the two strobes swap roles.
- R4: cfg_gate = 0 passes the strobes unconditionally. A value of 1 passes them only while the synchronised frame sync is 0, and 2 passes them only while it is 1. The reserved value 3 blocks both enables.
- R5: With cfg_start_sel = 0, a start pulse is issued in the cycle after rx_en rises while the block is idle. A start pulse is also issued in the cycle after the last bit of each word is sampled.
- R6: cfg_start_sel = 1 starts on tx_start and cfg_start_sel = 8 starts on cmp0_match. In both cases start_pulse is high in the cycle after the strobe.
- R7: cfg_start_sel = 2 starts on a low synchronised frame sync and 3 starts on a high one. start_pulse appears 3 cycles after fs_in changes: two synchroniser flops, then the start register.
- R8: cfg_start_sel = 4 starts on a falling edge of fs_in and 5 starts on a rising edge. Values 6 and 7 both start on either transition. The latency is 3 cycles, as in R7. An edge of the wrong direction gives no start.
- R9: cfg_start_sel values 9 to 15 never produce a start pulse, whatever fs_in, tx_start and cmp0_match do.
- R10: start_pulse sets busy in the same cycle. busy falls after cfg_word_len+1 enabled samples. While busy, a non-continuous trigger is ignored.
- R11: cfg_clk_out_mode 0 (and the reserved 3) keeps clk_out_en and clk_out_val at 0. Mode 1 drives clk_out_en = 1 and clk_out_val follows the selected source's level, which changes one cycle after each strobe. Mode 2 drives that level only while busy. cfg_inv and cfg_gate do not affect clk_out_val.
- R12: While rx_en is 0, no start pulse is issued, and busy is 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| cfg_start_sel | input | 4 | Start condition select |
| cfg_clk_src | input | 2 | Bit-clock source select |
| cfg_gate | input | 2 | Frame-sync clock qualification |
| cfg_inv | input | 1 | Sampling edge select |
| cfg_clk_out_mode | input | 2 | Receive clock output mode |
| cfg_word_len | input | LEN_W | Bits per word minus one |
| div_rise | input | 1 | Divided clock rise strobe |
| div_fall | input | 1 | Divided clock fall strobe |
| tx_rise | input | 1 | Transmit clock rise strobe |
| tx_fall | input | 1 | Transmit clock fall strobe |
| pin_rise | input | 1 | External clock pin rise strobe |
| pin_fall | input | 1 | External clock pin fall strobe |
| fs_in | input | 1 | Receive frame sync, asynchronous |
| tx_start | input | 1 | Transmitter start strobe |
| cmp0_match | input | 1 | Compare pattern 0 match strobe |
| smp_en | output | 1 | Data and frame sync sample enable |
| fs_out_en | output | 1 | Frame sync output shift enable |
| clk_out_en | output | 1 | Receive clock pin output enable |
| clk_out_val | output | 1 | Receive clock pin output level |
| start_pulse | output | 1 | Word start pulse |
| busy | output | 1 | Word in progress |

## Verification
The bench goes after the following corner cases, each of which shows a particular fault:
- Start latency is checked by cycle number. An extra or missing synchroniser stage, or an unregistered start, moves every frame-sync pulse by a cycle.
- Edges of the wrong direction and the reserved start codes are driven with every trigger input toggling. A decoder that treats the start modes loosely then shows a stray pulse.
- Continuous mode is run across a word boundary to confirm back-to-back restart on the final sample. A counter that is off by one ends the word a sample early or late.
- Inversion, gating and source selection are probed strobe by strobe. This catches a swapped edge, or inversion leaking onto the clock output pin.

// File: rtl/rx_ctl_pkg.sv
package rx_ctl_pkg;
  localparam int N_SRC  = 3;
  localparam int SRC_W  = 2;
  localparam int SEL_W  = 4;

  localparam logic [SEL_W-1:0] ST_CONT   = 4'd0;
  localparam logic [SEL_W-1:0] ST_TXSTRT = 4'd1;
  localparam logic [SEL_W-1:0] ST_LOW    = 4'd2;
  localparam logic [SEL_W-1:0] ST_HIGH   = 4'd3;
  localparam logic [SEL_W-1:0] ST_FALL   = 4'd4;
  localparam logic [SEL_W-1:0] ST_RISE   = 4'd5;
  localparam logic [SEL_W-1:0] ST_CHG    = 4'd6;
  localparam logic [SEL_W-1:0] ST_ANY    = 4'd7;
  localparam logic [SEL_W-1:0] ST_CMP    = 4'd8;

  localparam logic [1:0] GT_FREE = 2'd0;
  localparam logic [1:0] GT_LOW  = 2'd1;
  localparam logic [1:0] GT_HIGH = 2'd2;

  localparam logic [1:0] CO_NONE = 2'd0;
  localparam logic [1:0] CO_CONT = 2'd1;
  localparam logic [1:0] CO_XFER = 2'd2;
endpackage

// File: rtl/rx_fs_sync.sv
module rx_fs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_in,
  output logic fs_lvl,
  output logic fs_prev
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], fs_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign fs_lvl  = chain_q[STAGES-1];
  assign fs_prev = prev_q;
endmodule

// File: rtl/rx_clk_sel.sv
module rx_clk_sel
  import rx_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] rise_v,
  input  logic [N_SRC-1:0] fall_v,
  input  logic [SRC_W-1:0] cfg_clk_src,
  input  logic [1:0]       cfg_gate,
  input  logic             cfg_inv,
  input  logic [1:0]       cfg_clk_out_mode,
  input  logic             fs_lvl,
  input  logic             busy,
  output logic             smp_en,
  output logic             fs_out_en,
  output logic             clk_out_en,
  output logic             clk_out_val
);
  logic sel_rise, sel_fall, gate_ok;
  logic lvl_q, lvl_d;

  always_comb begin
    sel_rise = 1'b0;
    sel_fall = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (cfg_clk_src == SRC_W'(i)) begin
        sel_rise = rise_v[i];
        sel_fall = fall_v[i];
      end
    end
  end

  always_comb begin
    case (cfg_gate)
      GT_FREE: gate_ok = 1'b1;
      GT_LOW:  gate_ok = ~fs_lvl;
      GT_HIGH: gate_ok = fs_lvl;
      default: gate_ok = 1'b0;
    endcase
  end

  always_comb begin
    smp_en    = gate_ok & (cfg_inv ? sel_rise : sel_fall);
    fs_out_en = gate_ok & (cfg_inv ? sel_fall : sel_rise);
  end

  always_comb begin
    lvl_d = lvl_q;
    if (sel_rise)      lvl_d = 1'b1;
    else if (sel_fall) lvl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  always_comb begin
    case (cfg_clk_out_mode)
      CO_CONT: begin clk_out_en = 1'b1; clk_out_val = lvl_q;        end
      CO_XFER: begin clk_out_en = 1'b1; clk_out_val = lvl_q & busy; end
      default: begin clk_out_en = 1'b0; clk_out_val = 1'b0;         end
    endcase
  end
endmodule

// File: rtl/rx_start_det.sv
module rx_start_det
  import rx_ctl_pkg::*;
(
  input  logic [SEL_W-1:0] cfg_start_sel,
  input  logic             rx_en,
  input  logic             fs_lvl,
  input  logic             fs_prev,
  input  logic             tx_start,
  input  logic             cmp0_match,
  input  logic             busy,
  input  logic             last_bit,
  output logic             start_req
);
  logic trig, allow;

  always_comb begin
    case (cfg_start_sel)
      ST_CONT:        trig = 1'b1;
      ST_TXSTRT:      trig = tx_start;
      ST_LOW:         trig = ~fs_lvl;
      ST_HIGH:        trig = fs_lvl;
      ST_FALL:        trig = fs_prev & ~fs_lvl;
      ST_RISE:        trig = ~fs_prev & fs_lvl;
      ST_CHG, ST_ANY: trig = fs_prev ^ fs_lvl;
      ST_CMP:         trig = cmp0_match;
      default:        trig = 1'b0;
    endcase
    allow     = (cfg_start_sel == ST_CONT) ? (~busy | last_bit) : ~busy;
    start_req = rx_en & trig & allow;
  end
endmodule

// File: rtl/rx_word_ctr.sv
module rx_word_ctr #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             start_req,
  input  logic             smp_en,
  input  logic [LEN_W-1:0] cfg_word_len,
  output logic             busy,
  output logic             last_bit,
  output logic             start_pulse
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             strt_q;

  assign last_bit = busy_q & smp_en & (cnt_q == cfg_word_len);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (!rx_en) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (start_req) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q && smp_en) begin
      if (last_bit) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      strt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      strt_q <= start_req;
    end
  end

  assign busy        = busy_q;
  assign start_pulse = strt_q;
endmodule

// File: rtl/rx_start_clk_ctrl.sv
module rx_start_clk_ctrl
  import rx_ctl_pkg::*;
#(
  parameter int LEN_W     = 5,
  parameter int FS_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic [3:0]       cfg_start_sel,
  input  logic [1:0]       cfg_clk_src,
  input  logic [1:0]       cfg_gate,
  input  logic             cfg_inv,
  input  logic [1:0]       cfg_clk_out_mode,
  input  logic [LEN_W-1:0] cfg_word_len,
  input  logic             div_rise,
  input  logic             div_fall,
  input  logic             tx_rise,
  input  logic             tx_fall,
  input  logic             pin_rise,
  input  logic             pin_fall,
  input  logic             fs_in,
  input  logic             tx_start,
  input  logic             cmp0_match,
  output logic             smp_en,
  output logic             fs_out_en,
  output logic             clk_out_en,
  output logic             clk_out_val,
  output logic             start_pulse,
  output logic             busy
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       fs_lvl, fs_prev, start_req, last_bit;
  logic [N_SRC-1:0] rise_v, fall_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign rise_v = {pin_rise, tx_rise, div_rise};
  assign fall_v = {pin_fall, tx_fall, div_fall};

  rx_fs_sync #(.STAGES(FS_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .fs_in(fs_in),
    .fs_lvl(fs_lvl), .fs_prev(fs_prev)
  );

  rx_clk_sel u_clk (
    .clk(clk), .rst_n(rst_int_n), .rise_v(rise_v), .fall_v(fall_v),
    .cfg_clk_src(cfg_clk_src), .cfg_gate(cfg_gate), .cfg_inv(cfg_inv),
    .cfg_clk_out_mode(cfg_clk_out_mode), .fs_lvl(fs_lvl), .busy(busy),
    .smp_en(smp_en), .fs_out_en(fs_out_en),
    .clk_out_en(clk_out_en), .clk_out_val(clk_out_val)
  );

  rx_start_det u_det (
    .cfg_start_sel(cfg_start_sel), .rx_en(rx_en), .fs_lvl(fs_lvl),
    .fs_prev(fs_prev), .tx_start(tx_start), .cmp0_match(cmp0_match),
    .busy(busy), .last_bit(last_bit), .start_req(start_req)
  );

  rx_word_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk(clk), .rst_n(rst_int_n), .rx_en(rx_en), .start_req(start_req),
    .smp_en(smp_en), .cfg_word_len(cfg_word_len), .busy(busy),
    .last_bit(last_bit), .start_pulse(start_pulse)
  );
endmodule

// File: rtl/rx_start_clk_ctrl_chk.sv
module rx_start_clk_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic [3:0] cfg_start_sel,
  input logic [1:0] cfg_clk_src,
  input logic [1:0] cfg_gate,
  input logic [1:0] cfg_clk_out_mode,
  input logic       smp_en,
  input logic       fs_out_en,
  input logic       clk_out_en,
  input logic       clk_out_val,
  input logic       start_pulse,
  input logic       busy
);
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> busy);

  p_reserved_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_start_sel > 4'd8) |=> !start_pulse);

  p_gate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_gate == 2'd3) |-> (!smp_en && !fs_out_en));

  p_src_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk_src == 2'd3) |-> (!smp_en && !fs_out_en));

  p_out_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk_out_mode == 2'd0) |-> (!clk_out_en && !clk_out_val));

  p_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!start_pulse && !busy));
endmodule

bind rx_start_clk_ctrl rx_start_clk_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cfg_start_sel(cfg_start_sel),
  .cfg_clk_src(cfg_clk_src), .cfg_gate(cfg_gate),
  .cfg_clk_out_mode(cfg_clk_out_mode), .smp_en(smp_en),
  .fs_out_en(fs_out_en), .clk_out_en(clk_out_en),
  .clk_out_val(clk_out_val), .start_pulse(start_pulse), .busy(busy)
);

// File: tb/tb_rx_start_clk_ctrl.sv
module tb_rx_start_clk_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic rx_en, cfg_inv, fs_in, tx_start, cmp0_match;
  logic [3:0] cfg_start_sel;
  logic [1:0] cfg_clk_src, cfg_gate, cfg_clk_out_mode;
  logic [4:0] cfg_word_len;
  logic [5:0] stb;
  logic smp_en, fs_out_en, clk_out_en, clk_out_val, start_pulse, busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int    exp_cyc[$];
  string exp_tag[$];
  string cur_tag = "R9";

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rx_start_clk_ctrl dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cfg_start_sel(cfg_start_sel),
    .cfg_clk_src(cfg_clk_src), .cfg_gate(cfg_gate), .cfg_inv(cfg_inv),
    .cfg_clk_out_mode(cfg_clk_out_mode), .cfg_word_len(cfg_word_len),
    .div_rise(stb[0]), .div_fall(stb[1]), .tx_rise(stb[2]), .tx_fall(stb[3]),
    .pin_rise(stb[4]), .pin_fall(stb[5]), .fs_in(fs_in), .tx_start(tx_start),
    .cmp0_match(cmp0_match), .smp_en(smp_en), .fs_out_en(fs_out_en),
    .clk_out_en(clk_out_en), .clk_out_val(clk_out_val),
    .start_pulse(start_pulse), .busy(busy)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_start(input int c, input string tag);
    exp_cyc.push_back(c);
    exp_tag.push_back(tag);
  endtask

  // scoreboard monitor: every start pulse must match the next expected cycle
  always @(negedge clk) begin
    if (rst_n && start_pulse) begin
      checks++;
      if (exp_cyc.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected start pulse actual cycle %0d expected none", cur_tag, cyc);
      end else begin
        int    c;
        string t;
        c = exp_cyc.pop_front();
        t = exp_tag.pop_front();
        if (c != cyc) begin
          errors++;
          $display("FAIL %s start pulse actual cycle %0d expected %0d", t, cyc, c);
        end
      end
    end
  end

  // one strobe for one cycle, enables checked mid-cycle
  task automatic strobe_chk(input int idx, input logic e_smp, input logic e_fso, input string tag);
    stb = 6'b0;
    stb[idx] = 1'b1;
    #2;
    chk(smp_en, e_smp, {tag, " smp_en"});
    chk(fs_out_en, e_fso, {tag, " fs_out_en"});
    tick();
    stb = 6'b0;
  endtask

  task automatic strobe(input int idx);
    stb = 6'b0;
    stb[idx] = 1'b1;
    tick();
    stb = 6'b0;
  endtask

  task automatic arm(input logic [3:0] sel, input logic fs_idle);
    rx_en = 1'b0;
    cfg_start_sel = sel;
    fs_in = fs_idle;
    tick(4);
    rx_en = 1'b1;
    tick();
  endtask

  task automatic fs_event(input logic v, input string tag, input logic want);
    cur_tag = tag;
    fs_in = v;
    if (want) expect_start(cyc + 3, tag);
    tick(4);
    rx_en = 1'b0;
    tick(2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b0; cfg_inv = 1'b0; fs_in = 1'b0;
    tx_start = 1'b0; cmp0_match = 1'b0; cfg_start_sel = 4'd15;
    cfg_clk_src = 2'd0; cfg_gate = 2'd0; cfg_clk_out_mode = 2'd0;
    cfg_word_len = 5'd0; stb = 6'b0;
    tick(3);
    // R1 reset state
    chk(smp_en, 1'b0, "R1 smp_en");
    chk(fs_out_en, 1'b0, "R1 fs_out_en");
    chk(clk_out_en, 1'b0, "R1 clk_out_en");
    chk(clk_out_val, 1'b0, "R1 clk_out_val");
    chk(start_pulse, 1'b0, "R1 start_pulse");
    chk(busy, 1'b0, "R1 busy");
    rst_n = 1'b1;
    tick(4);

    // R3 inversion
    cfg_inv = 1'b0;
    strobe_chk(0, 1'b0, 1'b1, "R3 inv0 rise");
    strobe_chk(1, 1'b1, 1'b0, "R3 inv0 fall");
    cfg_inv = 1'b1;
    strobe_chk(0, 1'b1, 1'b0, "R3 inv1 rise");
    strobe_chk(1, 1'b0, 1'b1, "R3 inv1 fall");
    cfg_inv = 1'b0;

    // R2 source selection
    cfg_clk_src = 2'd1;
    strobe_chk(3, 1'b1, 1'b0, "R2 src1 tx_fall");
    strobe_chk(1, 1'b0, 1'b0, "R2 src1 div_fall");
    cfg_clk_src = 2'd2;
    strobe_chk(5, 1'b1, 1'b0, "R2 src2 pin_fall");
    strobe_chk(3, 1'b0, 1'b0, "R2 src2 tx_fall");
    cfg_clk_src = 2'd3;
    strobe_chk(1, 1'b0, 1'b0, "R2 src3 div_fall");
    strobe_chk(5, 1'b0, 1'b0, "R2 src3 pin_fall");
    cfg_clk_src = 2'd0;

    // R4 gating
    cfg_gate = 2'd1; fs_in = 1'b0; tick(4);
    strobe_chk(1, 1'b1, 1'b0, "R4 gate1 fs low");
    fs_in = 1'b1; tick(4);
    strobe_chk(1, 1'b0, 1'b0, "R4 gate1 fs high");
    cfg_gate = 2'd2;
    strobe_chk(1, 1'b1, 1'b0, "R4 gate2 fs high");
    strobe_chk(0, 1'b0, 1'b1, "R4 gate2 fs high rise");
    fs_in = 1'b0; tick(4);
    strobe_chk(1, 1'b0, 1'b0, "R4 gate2 fs low");
    cfg_gate = 2'd3;
    strobe_chk(1, 1'b0, 1'b0, "R4 gate3");
    cfg_gate = 2'd0;

    // R11 clock output modes, inversion not applied
    cfg_clk_out_mode = 2'd1; cfg_inv = 1'b1;
    #2 chk(clk_out_en, 1'b1, "R11 mode1 oe");
    strobe(0);
    #1 chk(clk_out_val, 1'b1, "R11 mode1 after rise");
    tick();
    strobe(1);
    #1 chk(clk_out_val, 1'b0, "R11 mode1 after fall");
    tick();
    cfg_clk_out_mode = 2'd2;
    strobe(0);
    #1 chk(clk_out_val, 1'b0, "R11 mode2 idle");
    chk(clk_out_en, 1'b1, "R11 mode2 oe");
    cfg_clk_out_mode = 2'd0;
    #1 chk(clk_out_en, 1'b0, "R11 mode0 oe");
    chk(clk_out_val, 1'b0, "R11 mode0 val");
    tick();
    strobe(1);
    cfg_inv = 1'b0;

    // R6 transmit start and compare match
    arm(4'd1, 1'b0);
    cur_tag = "R6";
    tx_start = 1'b1; expect_start(cyc + 1, "R6 tx_start"); tick(); tx_start = 1'b0;
    tick(2); rx_en = 1'b0; tick(2);
    arm(4'd8, 1'b0);
    cmp0_match = 1'b1; expect_start(cyc + 1, "R6 cmp0_match"); tick(); cmp0_match = 1'b0;
    tick(2); rx_en = 1'b0; tick(2);

    // R7 levels
    arm(4'd2, 1'b1); fs_event(1'b0, "R7 low level", 1'b1);
    arm(4'd3, 1'b0); fs_event(1'b1, "R7 high level", 1'b1);

    // R8 edges
    arm(4'd4, 1'b1); fs_event(1'b0, "R8 falling edge", 1'b1);
    arm(4'd4, 1'b0); fs_event(1'b1, "R8 falling mode rising edge", 1'b0);
    arm(4'd5, 1'b0); fs_event(1'b1, "R8 rising edge", 1'b1);
    arm(4'd5, 1'b1); fs_event(1'b0, "R8 rising mode falling edge", 1'b0);
    arm(4'd6, 1'b0); fs_event(1'b1, "R8 change mode rise", 1'b1);
    arm(4'd7, 1'b1); fs_event(1'b0, "R8 any edge fall", 1'b1);

    // R9 reserved codes
    for (int s = 9; s < 16; s++) begin
      arm(4'(s), 1'b0);
      cur_tag = "R9";
      fs_in = 1'b1; tx_start = 1'b1; cmp0_match = 1'b1; tick();
      tx_start = 1'b0; cmp0_match = 1'b0; tick(2);
      fs_in = 1'b0; tick(4);
      chk(busy, 1'b0, "R9 reserved busy");
      rx_en = 1'b0; tick();
    end

    // R10 word length and busy blocking
    cfg_word_len = 5'd2;
    arm(4'd1, 1'b0);
    cur_tag = "R10";
    tx_start = 1'b1; expect_start(cyc + 1, "R10 first"); tick(); tx_start = 1'b0;
    chk(busy, 1'b1, "R10 busy set");
    tx_start = 1'b1; tick(); tx_start = 1'b0;
    tick();
    strobe(1); strobe(1);
    chk(busy, 1'b1, "R10 busy after two samples");
    strobe(1);
    chk(busy, 1'b0, "R10 busy clear after three samples");
    tx_start = 1'b1; expect_start(cyc + 1, "R10 after word"); tick(); tx_start = 1'b0;
    tick();
    // R12 disable clears busy
    rx_en = 1'b0; tick();
    chk(busy, 1'b0, "R12 busy cleared by disable");
    tx_start = 1'b1; tick(); tx_start = 1'b0; tick(2);
    chk(busy, 1'b0, "R12 no start while disabled");

    // R5 continuous back-to-back
    cfg_word_len = 5'd1; cfg_start_sel = 4'd0; tick(2);
    cur_tag = "R5";
    rx_en = 1'b1; expect_start(cyc + 1, "R5 enable start"); tick(2);
    strobe(1); tick();
    expect_start(cyc + 1, "R5 back-to-back");
    strobe(1);
    chk(busy, 1'b1, "R5 busy stays");
    tick(3);
    rx_en = 1'b0; tick(3);

    checks++;
    if (exp_cyc.size() != 0) begin
      errors++;
      $display("FAIL scoreboard actual %0d pending expected 0", exp_cyc.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule